// File: doc/BRIEF.md
# Pended Bus Priority Arbiter

This block decides, once per bus cycle, which of four nodes may drive a shared synchronous, multiplexed, pended system bus. The nodes are the memory controller's read-return path, two I/O adapter nodes and a CPU. Each node raises a request line. The arbiter answers with a registered grant vector that has at most one bit set. When no node wins, the arbiter acts as the default master, and its no-operation flag tells the bus interface to drive an idle cycle.

Priority has three tiers. The memory return path is at the top. The two I/O nodes form the middle tier and take turns by round-robin. The CPU is at the bottom.

A legacy mode supports a latency-critical peripheral that sits behind I/O node 2. In this mode, I/O node 2 can raise a hint while a critical read is pending. The hint freezes every other grant until memory reports that it has accepted the read, or until the hint drops. While the hint is up, buffered-write requests from I/O node 2 are held back.

Top module: `pbus_arb`

## Requirements
- R1: `gnt_o` is registered and has at most one bit set. Bit 0 is memory, bit 1 is I/O node 1, bit 2 is I/O node 2 and bit 3 is the CPU. The grant reflects the inputs sampled at the previous rising edge, and each grant lasts exactly one cycle before arbitration runs again.
- R2: Outside a hint hold, a memory return request always wins, whatever the other requests are.
- R3: When both I/O nodes request and memory does not, they are granted alternately. After reset, I/O node 1 is served first.
- R4: The CPU is granted only when no unmasked memory or I/O request is present.
- R5: In a cycle with no grant, `gnt_o` is zero and `nop_o` is 1. During reset the grant is zero and `nop_o` is 1.
- R6: A hold is active when `legacy_en_i` and `crit_hint_i` are both 1 and no accept has yet been seen for the current hint. During a hold, only I/O node 2 can be granted.
- R7: A cycle with `crit_accept_i` at 1 while the hint is up ends the hold from the next cycle onward. The hold arms again only after the hint has been 0 for at least one cycle.
- R8: While `legacy_en_i` and `crit_hint_i` are both 1, a request from I/O node 2 that is marked as a buffered write (`crit_wr_i` = 1) is not granted. This applies both inside and after the hold.
- R9: With `legacy_en_i` at 0, `crit_hint_i`, `crit_wr_i` and `crit_accept_i` have no effect on any grant.
- R10: The round-robin turn changes only in a cycle where an I/O node is granted. Memory grants, CPU grants and idle cycles leave the turn unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rtn_req_i | input | 1 | Memory read-return path requests the bus |
| io_req_i | input | 2 | I/O node requests; bit 0 is node 1, bit 1 is node 2 |
| cpu_req_i | input | 1 | CPU requests the bus |
| legacy_en_i | input | 1 | Enables latency-critical peripheral mode |
| crit_hint_i | input | 1 | I/O node 2 has a critical read pending |
| crit_wr_i | input | 1 | The current I/O node 2 request is a buffered write |
| crit_accept_i | input | 1 | Memory has accepted the flagged read |
| gnt_o | output | 4 | One-hot grant for the current bus cycle |
| nop_o | output | 1 | No node is granted; drive an idle cycle |

## Verification
A round-robin turn that is wrong shows up at the ports on the next cycle in which both I/O nodes contend. That cycle grants the wrong I/O node, so the stimulus places CPU-only and memory-only cycles between contended I/O cycles to expose a turn that moved when it should not have.

A hold flag that is stuck or cleared early appears in the very next registered grant. A stuck flag blocks memory after the accept. A flag cleared early lets memory or I/O node 1 through during the hint.

A mid-run reset taken while the turn favours node 2 shows whether reset restores the turn to node 1.

// File: rtl/pbus_arb_pkg.sv
package pbus_arb_pkg;
  // Grant vector layout: memory at the bottom, I/O nodes next, CPU on top.
  localparam int unsigned SLOT_MEM = 0;
  localparam int unsigned SLOT_IO0 = 1;

  function automatic int unsigned cpu_slot(input int unsigned n_io);
    return n_io + 1;
  endfunction
endpackage

// File: rtl/pbus_arb_hold.sv
module pbus_arb_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy_en_i,
  input  logic hint_i,
  input  logic accept_i,
  output logic hold_o,
  output logic wr_block_o
);
  logic served_q;
  logic served_d;
  logic served_en;

  always_comb begin
    served_en = 1'b1;
    served_d  = hint_i & (served_q | (legacy_en_i & accept_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      served_q <= 1'b0;
    end else if (served_en) begin
      served_q <= served_d;
    end
  end

  assign hold_o     = legacy_en_i & hint_i & ~served_q;
  assign wr_block_o = legacy_en_i & hint_i;

  AST_ACCEPT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_en_i && hint_i && accept_i) |=> !hold_o); // R7
  AST_DROP_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    !hint_i |=> (hold_o == (legacy_en_i && hint_i))); // R7
endmodule

// File: rtl/pbus_arb_rr.sv
module pbus_arb_rr #(
  parameter int unsigned NUM_IO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IO-1:0] req_i,
  input  logic              take_i,
  output logic [NUM_IO-1:0] pick_o
);
  localparam int unsigned PW = (NUM_IO > 1) ? $clog2(NUM_IO) : 1;
  localparam logic [PW-1:0] LAST = PW'(NUM_IO - 1);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_d;
  logic [PW-1:0] pick_idx;
  logic          found;

  always_comb begin
    int unsigned idx;
    pick_o   = '0;
    pick_idx = ptr_q;
    found    = 1'b0;
    for (int unsigned k = 0; k < NUM_IO; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= NUM_IO) idx = idx - NUM_IO;
      if (!found && req_i[idx]) begin
        found       = 1'b1;
        pick_o[idx] = 1'b1;
        pick_idx    = PW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (take_i) begin
      ptr_d = (pick_idx == LAST) ? '0 : pick_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (take_i) begin
      ptr_q <= ptr_d;
    end
  end

  AST_TURN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(ptr_q)); // R10
  AST_TURN_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    req_i[ptr_q] |-> pick_o[ptr_q]); // R3
endmodule

// File: rtl/pbus_arb_prio.sv
module pbus_arb_prio #(
  parameter int unsigned NUM_IO = 2
) (
  input  logic              mem_i,
  input  logic [NUM_IO-1:0] io_pick_i,
  input  logic              cpu_i,
  output logic [NUM_IO+1:0] gnt_d_o,
  output logic              io_win_o
);
  import pbus_arb_pkg::*;

  always_comb begin
    gnt_d_o  = '0;
    io_win_o = 1'b0;
    if (mem_i) begin
      gnt_d_o[SLOT_MEM] = 1'b1;
    end else if (|io_pick_i) begin
      gnt_d_o[SLOT_IO0 +: NUM_IO] = io_pick_i;
      io_win_o = 1'b1;
    end else if (cpu_i) begin
      gnt_d_o[cpu_slot(NUM_IO)] = 1'b1;
    end
  end
endmodule

// File: rtl/pbus_arb.sv
module pbus_arb #(
  parameter int unsigned NUM_IO = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_rtn_req_i,
  input  logic [NUM_IO-1:0] io_req_i,
  input  logic              cpu_req_i,
  input  logic              legacy_en_i,
  input  logic              crit_hint_i,
  input  logic              crit_wr_i,
  input  logic              crit_accept_i,
  output logic [NUM_IO+1:0] gnt_o,
  output logic              nop_o
);
  import pbus_arb_pkg::*;

  localparam int unsigned NODES  = NUM_IO + 2;
  localparam int unsigned CRIT   = NUM_IO - 1;
  localparam int unsigned CPU    = NUM_IO + 1;
  localparam int unsigned CSLOT  = SLOT_IO0 + CRIT;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_sn = rsync_q[1];

  logic              hold;
  logic              wr_block;
  logic [NUM_IO-1:0] io_eff;
  logic [NUM_IO-1:0] io_pick;
  logic              mem_eff;
  logic              cpu_eff;
  logic              io_win;
  logic [NODES-1:0]  gnt_d;
  logic [NODES-1:0]  gnt_q;
  logic              gnt_en;

  pbus_arb_hold u_hold (
    .clk         (clk),
    .rst_n       (rst_sn),
    .legacy_en_i (legacy_en_i),
    .hint_i      (crit_hint_i),
    .accept_i    (crit_accept_i),
    .hold_o      (hold),
    .wr_block_o  (wr_block)
  );

  generate
    for (genvar i = 0; i < NUM_IO; i++) begin : g_iomask
      if (i == CRIT) begin : g_crit
        assign io_eff[i] = io_req_i[i] & ~(wr_block & crit_wr_i);
      end else begin : g_plain
        assign io_eff[i] = io_req_i[i] & ~hold;
      end
    end
  endgenerate

  assign mem_eff = mem_rtn_req_i & ~hold;
  assign cpu_eff = cpu_req_i & ~hold;

  pbus_arb_rr #(.NUM_IO(NUM_IO)) u_rr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .req_i  (io_eff),
    .take_i (io_win),
    .pick_o (io_pick)
  );

  pbus_arb_prio #(.NUM_IO(NUM_IO)) u_prio (
    .mem_i     (mem_eff),
    .io_pick_i (io_pick),
    .cpu_i     (cpu_eff),
    .gnt_d_o   (gnt_d),
    .io_win_o  (io_win)
  );

  assign gnt_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      gnt_q <= '0;
    end else if (gnt_en) begin
      gnt_q <= gnt_d;
    end
  end

  assign gnt_o = gnt_q;
  assign nop_o = ~|gnt_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(gnt_q)); // R1
  AST_MEM_FIRST: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_rtn_req_i && !hold) |=> gnt_q[SLOT_MEM]); // R2
  AST_CPU_LAST: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_req_i && (mem_eff || (io_eff != '0))) |=> !gnt_q[CPU]); // R4
  AST_HOLD_ONLY: assert property (@(posedge clk) disable iff (!rst_sn)
    hold |=> ((gnt_q & ~(NODES'(1) << CSLOT)) == '0)); // R6
  AST_WR_MASK: assert property (@(posedge clk) disable iff (!rst_sn)
    (legacy_en_i && crit_hint_i && crit_wr_i) |=> !gnt_q[CSLOT]); // R8
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_sn)
    (!mem_rtn_req_i && (io_req_i == '0) && !cpu_req_i) |=> nop_o); // R5
endmodule

// File: tb/pbus_arb_test.sv
`timescale 1ns/1ps
module pbus_arb_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mem_req, cpu_req, leg, hint, wr, acc;
  logic [1:0] io_req;
  logic [3:0] gnt;
  logic       nop;
  int         checks = 0;
  int         fails  = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  pbus_arb uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_rtn_req_i (mem_req),
    .io_req_i      (io_req),
    .cpu_req_i     (cpu_req),
    .legacy_en_i   (leg),
    .crit_hint_i   (hint),
    .crit_wr_i     (wr),
    .crit_accept_i (acc),
    .gnt_o         (gnt),
    .nop_o         (nop)
  );

  // {leg, hint, accept, wr, cpu, io2, io1, mem, expected gnt[3:0]}
  // gnt bits: 0 memory, 1 I/O node 1, 2 I/O node 2, 3 CPU
  localparam int NV = 21;
  localparam logic [11:0] VEC [NV] = '{
    12'b0000_0000_0000, // R5 idle
    12'b0000_1000_1000, // R4 CPU alone
    12'b0000_1111_0001, // R2 memory beats all
    12'b0000_1110_0010, // R3 node 1 first
    12'b0000_1110_0100, // R3 node 2 next
    12'b0000_0110_0010, // R3 back to node 1
    12'b0000_0010_0010, // R3 node 1 alone
    12'b0000_1000_1000, // R10 CPU grant keeps the turn
    12'b0000_0110_0100, // R10 turn still at node 2
    12'b0000_0101_0001, // R2 memory over node 2
    12'b0100_1011_0001, // R9 hint ignored without mode
    12'b1100_1011_0000, // R6 hold blocks others
    12'b1101_0110_0000, // R8 write from node 2 masked
    12'b1100_0111_0100, // R6 only node 2 granted
    12'b1110_0011_0000, // R7 accept cycle still held
    12'b1100_0011_0001, // R7 released after accept
    12'b1101_0100_0000, // R8 write masked after release
    12'b1000_0100_0100, // R7 hint low clears
    12'b1100_0001_0000, // R7 hold armed again
    12'b0101_0100_0100, // R9 write marker ignored without mode
    12'b0000_0000_0000  // R5 idle
  };

  task automatic check(input string tag, input logic [3:0] exp_g);
    checks++;
    if (gnt !== exp_g) begin
      fails++;
      $display("FAIL %s gnt=%b expected %b", tag, gnt, exp_g);
    end
    checks++;
    if (nop !== (exp_g == 4'b0000)) begin
      fails++;
      $display("FAIL %s nop=%b expected %b", tag, nop, (exp_g == 4'b0000));
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {leg, hint, acc, wr, cpu_req, io_req[1], io_req[0], mem_req} = v;
  endtask

  task automatic do_reset();
    drive(8'h00);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    drive(8'h00);
    rst_n = 1'b0;
    #1;
    check("R5 reset", 4'b0000);
    @(negedge clk);
    check("R5 reset held", 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 after release", 4'b0000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][11:4]);
      @(negedge clk);
      check($sformatf("R1 vector %0d", i), VEC[i][3:0]);
    end

    // R3: reset restores the turn to node 1
    drive(8'b0000_0010);
    @(negedge clk);
    check("R3 set turn to node 2", 4'b0010);
    drive(8'b0000_0110);
    rst_n = 1'b0;
    #1;
    check("R5 async reset clears grant", 4'b0000);
    do_reset();
    drive(8'b0000_0110);
    @(negedge clk);
    check("R3 node 1 first after reset", 4'b0010);
    @(negedge clk);
    check("R1 one cycle per grant", 4'b0100);

    // R10: memory grant leaves the turn
    drive(8'b0000_0001);
    @(negedge clk);
    check("R10 memory grant", 4'b0001);
    drive(8'b0000_0110);
    @(negedge clk);
    check("R10 turn kept at node 1", 4'b0010);

    // R6/R7: hint drop ends hold without accept
    drive(8'b1100_0011);
    @(negedge clk);
    check("R6 hold blocks memory", 4'b0000);
    drive(8'b1000_0011);
    @(negedge clk);
    check("R7 hint low releases", 4'b0001);

    drive(8'h00);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule